// File: doc/BRIEF.md
# Detector Clock Pattern Sequencer

The block drives a set of detector clock lines straight from a pattern memory. Each stored word is one time step and each bit of that word is one clock line, so a waveform of any shape is a run of consecutive words. A sequence is a run of words that begins at a start address and ends at a word whose end marker is set. After that word, the address counter reloads from a pointer register and a new sequence begins with no gap.

Software fills the memory while the block is in load mode. It then selects operate mode and issues a run command. At the first word of every sequence the block raises an interrupt, which asks the host for the start address of the following sequence. The host may write that address at any point during the current sequence. The new address takes effect only at the next boundary. If the host writes nothing, the same sequence repeats, and the detector stays clocked while idle.

The memory is held inside the block at a reduced, parameterised depth.

Top module: `clkpat_sequencer`

## Requirements
- R1: After reset, `clk_lines`, `seq_irq` and `seq_flag` are all 0 and the next-start pointer is address 0.
- R2: While `op_mode` is 0 (load), a write with `pat_we` high stores `pat_data` and the end marker `pat_end` at `pat_addr`, and `clk_lines` reads 0.
- R3: A write with `pat_we` high while `op_mode` is 1 (operate) leaves the memory unchanged.
- R4: No word is output until a `run` pulse is sampled while `op_mode` is 1; a `run` pulse sampled while `op_mode` is 0 is ignored.
- R5: One cycle after `run` is sampled, `clk_lines` shows the word at the pointer address, and each later cycle shows the word at the next higher address.
- R6: In the cycle after `clk_lines` shows a word whose end marker is 1, `clk_lines` shows the word at the pointer address. No idle cycle comes between the two.
- R7: If the pointer is not written, every sequence starts at the same address as the previous one.
- R8: A pointer write (`ptr_we` high, address on `ptr_data`) sampled before the edge that outputs the last word of a sequence sets the start of the very next sequence.
- R9: A pointer write sampled on the same edge that outputs a sequence's last word does not affect the next sequence. It sets the start of the sequence after that.
- R10: `seq_irq` is 1 in exactly those cycles in which `clk_lines` shows the first word of a sequence.
- R11: `seq_flag` becomes 1 together with `seq_irq` and stays 1 until a cycle with `irq_clr` high and no new interrupt. When both occur in the same cycle, the set takes priority.
- R12: When `op_mode` falls to 0, `clk_lines` and `seq_irq` read 0 at once and sequencing stops. A later `run` starts again from the pointer address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pattern clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 1 | 0 = load, 1 = operate |
| run | input | 1 | Start command, sampled in operate mode |
| pat_we | input | 1 | Pattern memory write strobe |
| pat_addr | input | ADDR_W (8) | Pattern memory write address |
| pat_data | input | LINES (32) | Pattern word to store |
| pat_end | input | 1 | End-of-sequence marker stored with the word |
| ptr_we | input | 1 | Next-start pointer write strobe |
| ptr_data | input | ADDR_W (8) | Next sequence start address |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| clk_lines | output | LINES (32) | Detector clock line levels |
| seq_irq | output | 1 | One-cycle pulse with the first word of each sequence |
| seq_flag | output | 1 | Sticky copy of the sequence-start interrupt |

## Verification
The bench times one pointer write to land well inside a sequence and a second to land exactly on the reload edge. A design that applied the pointer at once would break a sequence off partway through. A design without deferral would skip the repeated sequence that the second write must leave in place. The bench writes to memory in operate mode before the run and checks the word at that address when it is played. A design that let the write through would play the new word. The bench also compares the interrupt cycle by cycle on the seams between sequences, where an off-by-one counter would put a gap word in the stream or mark the wrong word as first.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;
endpackage

// File: rtl/pattern_store.sv
module pattern_store #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LINES-1:0]  wdata_i,
  input  logic              wend_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [LINES-1:0]  rword_o,
  output logic              rend_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LINES-1:0] words_q [DEPTH];
  logic             ends_q  [DEPTH];
  logic             wr_en;

  // writes only in load mode
  assign wr_en = we_i && !op_i;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      words_q[waddr_i] <= wdata_i;
      ends_q[waddr_i]  <= wend_i;
    end
  end

  assign rword_o = words_q[raddr_i];
  assign rend_o  = ends_q[raddr_i];

  a_r3_locked_in_operate: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && op_i) |=> words_q[$past(waddr_i)] == $past(words_q[waddr_i]))
    else $error("pattern memory written in operate mode");
endmodule

// File: rtl/next_ptr.sv
module next_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] base_o
);
  logic [ADDR_W-1:0] stage_d, stage_q;

  always_comb begin
    stage_d = stage_q;
    if (we_i) stage_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign base_o = stage_q;

  a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(base_o))
    else $error("pointer changed without a write");
endmodule

// File: rtl/addr_gen.sv
module addr_gen
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_i,
  input  logic              run_i,
  input  logic              last_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              running_o,
  output logic              start_o
);
  seq_state_e        st_d, st_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              start_d, start_q;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    start_d = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (op_i && run_i) begin
          st_d    = SEQ_RUN;
          addr_d  = base_i;
          start_d = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (!op_i) begin
          st_d = SEQ_IDLE;
        end else if (last_i) begin
          addr_d  = base_i;
          start_d = 1'b1;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      addr_q  <= '0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      start_q <= start_d;
    end
  end

  assign addr_o    = addr_q;
  assign running_o = (st_q == SEQ_RUN);
  assign start_o   = start_q;

  a_r6_reload_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && op_i && last_i) |=> (addr_o == $past(base_i)) && start_o)
    else $error("no reload after end marker");
  a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && op_i && !last_i) |=> (addr_o == $past(addr_o) + 1'b1) && !start_o)
    else $error("address did not step");
  a_r12_stop_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !op_i |=> !running_o)
    else $error("still running in load mode");
endmodule

// File: rtl/line_out.sv
module line_out #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_i,
  input  logic             running_i,
  input  logic             start_i,
  input  logic [LINES-1:0] word_i,
  input  logic             clr_i,
  output logic [LINES-1:0] lines_o,
  output logic             irq_o,
  output logic             flag_o
);
  logic [LINES-1:0] lines_d, lines_q;
  logic             irq_d, irq_q;
  logic             flag_d, flag_q;
  logic             live;

  assign live = op_i && running_i;

  always_comb begin
    lines_d = live ? word_i : '0;
    irq_d   = live && start_i;
    flag_d  = irq_d || (flag_q && !clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '0;
      irq_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      lines_q <= lines_d;
      irq_q   <= irq_d;
      flag_q  <= flag_d;
    end
  end

  assign lines_o = lines_q & {LINES{op_i}};
  assign irq_o   = irq_q && op_i;
  assign flag_o  = flag_q;

  a_r11_flag_follows_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o)
    else $error("interrupt without sticky flag");
  a_r10_irq_only_live: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(running_i))
    else $error("interrupt while not sequencing");
endmodule

// File: rtl/clkpat_sequencer.sv
module clkpat_sequencer #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_mode,
  input  logic              run,
  input  logic              pat_we,
  input  logic [ADDR_W-1:0] pat_addr,
  input  logic [LINES-1:0]  pat_data,
  input  logic              pat_end,
  input  logic              ptr_we,
  input  logic [ADDR_W-1:0] ptr_data,
  input  logic              irq_clr,
  output logic [LINES-1:0]  clk_lines,
  output logic              seq_irq,
  output logic              seq_flag
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [ADDR_W-1:0] rd_addr, base;
  logic [LINES-1:0]  rd_word;
  logic              rd_end, running, start;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  pattern_store #(.LINES(LINES), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n_s), .op_i(op_mode), .we_i(pat_we),
    .waddr_i(pat_addr), .wdata_i(pat_data), .wend_i(pat_end),
    .raddr_i(rd_addr), .rword_o(rd_word), .rend_o(rd_end)
  );

  next_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n_s), .we_i(ptr_we), .data_i(ptr_data), .base_o(base)
  );

  addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .clk(clk), .rst_n(rst_n_s), .op_i(op_mode), .run_i(run), .last_i(rd_end),
    .base_i(base), .addr_o(rd_addr), .running_o(running), .start_o(start)
  );

  line_out #(.LINES(LINES)) u_out (
    .clk(clk), .rst_n(rst_n_s), .op_i(op_mode), .running_i(running),
    .start_i(start), .word_i(rd_word), .clr_i(irq_clr),
    .lines_o(clk_lines), .irq_o(seq_irq), .flag_o(seq_flag)
  );

  a_r2_quiet_in_load: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(!op_mode) && !op_mode |-> (clk_lines == '0) && !seq_irq)
    else $error("outputs active in load mode");
  a_r4_no_run_no_irq: assert property (@(posedge clk) disable iff (!rst_n_s)
    !running |=> !seq_irq)
    else $error("interrupt before run");
endmodule

// File: tb/sim_clkpat_sequencer.sv
module sim_clkpat_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int LINES  = 32;
  localparam int ADDR_W = 8;

  typedef struct {
    logic [LINES-1:0] word;
    logic             irq;
    string            req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, op_mode, run, pat_we, pat_end, ptr_we, irq_clr;
  logic [ADDR_W-1:0] pat_addr, ptr_data;
  logic [LINES-1:0]  pat_data, clk_lines;
  logic seq_irq, seq_flag;

  int n_checks = 0;
  int n_fails  = 0;
  bit mon_on   = 1'b0;
  bit done     = 1'b0;
  exp_t q[$];
  logic [LINES-1:0] m_word [1<<ADDR_W];
  logic             m_end  [1<<ADDR_W];

  always #(CLK_PERIOD/2) clk = ~clk;

  clkpat_sequencer #(.LINES(LINES), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .run(run),
    .pat_we(pat_we), .pat_addr(pat_addr), .pat_data(pat_data), .pat_end(pat_end),
    .ptr_we(ptr_we), .ptr_data(ptr_data), .irq_clr(irq_clr),
    .clk_lines(clk_lines), .seq_irq(seq_irq), .seq_flag(seq_flag)
  );

  task automatic check(input string req, input logic [LINES-1:0] act,
                       input logic [LINES-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  // monitor: pops expected items as the design emits them
  always @(negedge clk) begin
    if (mon_on && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.req, " lines"}, clk_lines, e.word);
      check({e.req, " irq"}, {31'b0, seq_irq}, {31'b0, e.irq});
    end
  end

  task automatic load_word(input int a, input logic [LINES-1:0] w, input logic e);
    @(negedge clk);
    pat_we = 1'b1; pat_addr = a[ADDR_W-1:0]; pat_data = w; pat_end = e;
    @(negedge clk);
    pat_we = 1'b0;
    m_word[a] = w; m_end[a] = e;
  endtask

  task automatic load_seq(input int start, input int len);
    for (int i = 0; i < len; i++)
      load_word(start + i, 32'h5A00_0000 ^ ((start + i) * 32'h0101_0103), i == len - 1);
  endtask

  // driver: push the expected stream of one sequence
  task automatic push_seq(input int start, input string req);
    int a;
    a = start;
    for (int k = 0; k < 64; k++) begin
      q.push_back('{word: m_word[a], irq: (k == 0), req: req});
      if (m_end[a]) break;
      a = (a + 1) % (1 << ADDR_W);
    end
  endtask

  task automatic start_run;
    @(negedge clk); run = 1'b1;
    @(posedge clk);
    @(negedge clk); run = 1'b0;
    @(posedge clk);
    #1 mon_on = 1'b1;
  endtask

  task automatic wait_size(input int n);
    for (int t = 0; t < 1000; t++) begin
      @(posedge clk);
      if (q.size() == n) break;
    end
  endtask

  task automatic write_ptr(input int a);
    @(negedge clk); ptr_we = 1'b1; ptr_data = a[ADDR_W-1:0];
    @(negedge clk); ptr_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; op_mode = 1'b0; run = 1'b0; pat_we = 1'b0; pat_end = 1'b0;
    ptr_we = 1'b0; irq_clr = 1'b0; pat_addr = '0; ptr_data = '0; pat_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 lines", clk_lines, '0);
    check("R1 irq",   {31'b0, seq_irq}, '0);
    check("R1 flag",  {31'b0, seq_flag}, '0);

    // R2: load three sequences in load mode
    load_seq(0, 4);
    load_seq(10, 2);
    load_seq(20, 3);
    @(negedge clk);
    check("R2 lines zero in load", clk_lines, '0);

    // R4: run while in load mode is ignored
    @(negedge clk); run = 1'b1;
    @(negedge clk); run = 1'b0; op_mode = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R4 no output before run", clk_lines, '0);
      check("R4 no irq before run", {31'b0, seq_irq}, '0);
    end

    // R3: write in operate mode must not reach memory (address 1)
    @(negedge clk);
    pat_we = 1'b1; pat_addr = 8'd1; pat_data = 32'hDEAD_BEEF; pat_end = 1'b1;
    @(negedge clk); pat_we = 1'b0;

    // R5/R6/R7/R8/R9/R10: A A A B B C C
    push_seq(0, "R5/R3");
    push_seq(0, "R7");
    push_seq(0, "R6");
    push_seq(10, "R8");
    push_seq(10, "R9");
    push_seq(20, "R10");
    push_seq(20, "R7 repeat");
    start_run();
    wait_size(13);          // next edge outputs third A, word 2
    write_ptr(10);
    wait_size(10);          // next edge outputs last word of first B: reload edge
    write_ptr(20);
    wait_size(0);
    mon_on = 1'b0;

    // R12: leaving operate blanks the outputs at once
    @(negedge clk); op_mode = 1'b0;
    #1 check("R12 lines zero at once", clk_lines, '0);
    check("R12 irq zero at once", {31'b0, seq_irq}, '0);
    repeat (3) @(negedge clk);
    check("R12 stopped", clk_lines, '0);

    // R11: sticky flag held, then cleared
    check("R11 flag held", {31'b0, seq_flag}, 32'd1);
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check("R11 flag cleared", {31'b0, seq_flag}, '0);

    // R12: restart from pointer written in load mode
    write_ptr(0);
    @(negedge clk); op_mode = 1'b1;
    push_seq(0, "R12 restart");
    start_run();
    wait_size(0);
    @(negedge clk);
    mon_on = 1'b0;
    check("R11 flag set again", {31'b0, seq_flag}, 32'd1);
    done = 1'b1;
    report();
  end
endmodule